// File: doc/BRIEF.md
# Interrupt Pin Repurposing and Trigger Qualifier

This block sits between a sensor's interrupt logic and its two interrupt pads. Each pad normally drives an interrupt level outward. A configuration bit per pad turns the pad around so that it becomes an input. When pad A is turned around, its input level is handed on as an external clock. When pad B is turned around, it carries an active-high sampling trigger. A pad that has been turned around no longer drives, so its interrupt cannot be seen. The two alternate roles are independent and may be active together.

The trigger is synchronized into the reference clock domain and then checked. A high phase must be at least a minimum number of cycles long. A low phase between pulses must also reach a minimum length, and rising edges must be at least a minimum period apart. The period limit corresponds to the highest supported trigger rate. Every pulse that passes all checks yields one single-cycle sample strobe when it falls. A pulse that fails any check yields no strobe and sets a sticky error flag, which software clears through a write-one-to-clear input.

Top module: `irq_pin_trigger`

## Requirements
- R1: With `clk_in_mode` = 0, `pin_a_oe` = 1 and `pin_a_out` equals `irq_a`. With `clk_in_mode` = 1, `pin_a_oe` = 0 and `pin_a_out` = 0.
- R2: With `trig_in_mode` = 0, `pin_b_oe` = 1 and `pin_b_out` equals `irq_b`. With `trig_in_mode` = 1, `pin_b_oe` = 0 and `pin_b_out` = 0. Pad B's setting is independent of pad A's.
- R3: `ext_clk` equals `pin_a_in` while `clk_in_mode` = 1 and is 0 otherwise.
- R4: Take the first rising clock edge at which `pin_b_in` is sampled low after a valid pulse. `sample_stb` is 1 for exactly the clock cycle that follows the third rising edge counted from that one.
- R5: A high phase lasting at least `MIN_HIGH_CYC` synchronized cycles gives exactly one strobe. A high phase that is one cycle shorter gives no strobe and sets `trig_err`.
- R6: A rising edge that comes fewer than `MIN_LOW_CYC` cycles after the previous falling edge marks that pulse as invalid: it sets `trig_err` and the pulse gives no strobe. A gap of exactly `MIN_LOW_CYC` cycles is accepted.
- R7: A rising edge that comes fewer than `MIN_PERIOD_CYC` cycles after the previous rising edge marks that pulse as invalid: it sets `trig_err` and the pulse gives no strobe. A spacing of exactly `MIN_PERIOD_CYC` cycles is accepted. The first pulse after reset or after the mode is enabled has no gap or period limit.
- R8: `trig_err` stays 1 until `err_clr` is 1 in a cycle with no new violation. If a violation and `err_clr` arrive together, the violation wins.
- R9: While `trig_in_mode` = 0, `pin_b_in` has no effect. No strobe is produced and `trig_err` is not set, whatever the pulse widths.
- R10: After reset, `sample_stb` = 0 and `trig_err` = 0, and both pads drive their interrupts when their mode bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_in_mode | input | 1 | Turns pad A into the external clock input |
| trig_in_mode | input | 1 | Turns pad B into the sample trigger input |
| irq_a | input | 1 | Interrupt level for pad A |
| irq_b | input | 1 | Interrupt level for pad B |
| pin_a_in | input | 1 | Level read from pad A |
| pin_b_in | input | 1 | Level read from pad B (asynchronous trigger) |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| pin_a_out | output | 1 | Level driven onto pad A |
| pin_a_oe | output | 1 | Output enable of pad A |
| pin_b_out | output | 1 | Level driven onto pad B |
| pin_b_oe | output | 1 | Output enable of pad B |
| ext_clk | output | 1 | External clock taken from pad A |
| sample_stb | output | 1 | One-cycle strobe for each qualified trigger |
| trig_err | output | 1 | Sticky flag for trigger timing violations |

## Verification
The qualifier holds only a level register, one phase counter, one period counter and a bad-pulse flag. Any fault in these state bits shows up at the ports within one pulse. A counter that is off by one moves the accept/reject boundary, which the exact-limit and limit-minus-one pulses expose. A bad-pulse flag that is lost or stuck shows as a missing or extra strobe, three edges after the falling edge. A wrong pad mux shows at once as a driven output enable on a pad that has been turned around.

// File: rtl/trigq_pkg.sv
package trigq_pkg;

  // Saturating increment: count up by one and stop at the limit.
  function automatic int unsigned sat_step(input int unsigned cnt, input int unsigned lim);
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction

  // True once a measured length has reached the required minimum.
  function automatic logic reaches(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pin_route.sv
module pin_route #(
  parameter int unsigned NPINS = 2
) (
  input  logic [NPINS-1:0] alt_mode,
  input  logic [NPINS-1:0] irq_lvl,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] alt_in
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // A pad in its alternate role is released and only listened to.
    assign pad_oe[i]  = ~alt_mode[i];
    assign pad_out[i] = irq_lvl[i] & ~alt_mode[i];
    assign alt_in[i]  = pad_in[i] & alt_mode[i];
  end
endmodule

// File: rtl/sync_2ff.sv
module sync_2ff (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trigq_pkg::*;
#(
  parameter int unsigned MIN_HIGH_CYC   = 1250,
  parameter int unsigned MIN_LOW_CYC    = 1250,
  parameter int unsigned MIN_PERIOD_CYC = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  input  logic err_clr,
  output logic sample_stb,
  output logic trig_err,
  output logic rise_evt,
  output logic fall_evt,
  output logic viol_evt
);
  localparam int unsigned PH_LIM = max2(MIN_HIGH_CYC, MIN_LOW_CYC);
  localparam int unsigned PH_W   = $clog2(PH_LIM + 1);
  localparam int unsigned PER_W  = $clog2(MIN_PERIOD_CYC + 1);

  logic             level_q;
  logic [PH_W-1:0]  phase_cnt;   // length of the current level so far
  logic [PER_W-1:0] per_cnt;     // cycles since the last rising edge
  logic             pulse_bad;
  logic             hi_ok;
  logic             gap_ok;

  assign rise_evt = en & lvl & ~level_q;
  assign fall_evt = en & ~lvl & level_q;

  // At a falling edge phase_cnt holds the high length; at a rising edge, the low length.
  assign hi_ok  = reaches(32'(phase_cnt), MIN_HIGH_CYC);
  assign gap_ok = reaches(32'(phase_cnt), MIN_LOW_CYC) & reaches(32'(per_cnt), MIN_PERIOD_CYC);

  assign viol_evt = (rise_evt & ~gap_ok) | (fall_evt & ~hi_ok);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      level_q   <= 1'b0;
      phase_cnt <= PH_W'(PH_LIM);
      per_cnt   <= PER_W'(MIN_PERIOD_CYC);
      pulse_bad <= 1'b0;
    end else begin
      level_q <= lvl;
      if (rise_evt || fall_evt) phase_cnt <= PH_W'(1);
      else                      phase_cnt <= PH_W'(sat_step(32'(phase_cnt), PH_LIM));
      if (rise_evt) per_cnt <= PER_W'(1);
      else          per_cnt <= PER_W'(sat_step(32'(per_cnt), MIN_PERIOD_CYC));
      if (rise_evt) pulse_bad <= ~gap_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_stb <= 1'b0;
      trig_err   <= 1'b0;
    end else begin
      sample_stb <= fall_evt & hi_ok & ~pulse_bad;
      trig_err   <= viol_evt | (trig_err & ~err_clr);
    end
  end
endmodule

// File: rtl/irq_pin_trigger.sv
module irq_pin_trigger #(
  parameter int unsigned MIN_HIGH_CYC   = 1250,
  parameter int unsigned MIN_LOW_CYC    = 1250,
  parameter int unsigned MIN_PERIOD_CYC = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in_mode,
  input  logic trig_in_mode,
  input  logic irq_a,
  input  logic irq_b,
  input  logic pin_a_in,
  input  logic pin_b_in,
  input  logic err_clr,
  output logic pin_a_out,
  output logic pin_a_oe,
  output logic pin_b_out,
  output logic pin_b_oe,
  output logic ext_clk,
  output logic sample_stb,
  output logic trig_err
);
  localparam int unsigned NPINS = 2;

  logic [NPINS-1:0] pad_out;
  logic [NPINS-1:0] pad_oe;
  logic [NPINS-1:0] alt_in;
  logic             trig_sync;
  logic             rise_evt;
  logic             fall_evt;
  logic             viol_evt;

  pin_route #(.NPINS(NPINS)) u_route (
    .alt_mode ({trig_in_mode, clk_in_mode}),
    .irq_lvl  ({irq_b, irq_a}),
    .pad_in   ({pin_b_in, pin_a_in}),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .alt_in   (alt_in)
  );

  assign pin_a_out = pad_out[0];
  assign pin_a_oe  = pad_oe[0];
  assign pin_b_out = pad_out[1];
  assign pin_b_oe  = pad_oe[1];
  assign ext_clk   = alt_in[0];

  sync_2ff u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (alt_in[1]),
    .q     (trig_sync)
  );

  trig_qualifier #(
    .MIN_HIGH_CYC   (MIN_HIGH_CYC),
    .MIN_LOW_CYC    (MIN_LOW_CYC),
    .MIN_PERIOD_CYC (MIN_PERIOD_CYC)
  ) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (trig_in_mode),
    .lvl        (trig_sync),
    .err_clr    (err_clr),
    .sample_stb (sample_stb),
    .trig_err   (trig_err),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .viol_evt   (viol_evt)
  );
endmodule

// File: rtl/irq_pin_trigger_chk.sv
module irq_pin_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_in_mode,
  input logic trig_in_mode,
  input logic pin_a_out,
  input logic pin_a_oe,
  input logic pin_b_out,
  input logic pin_b_oe,
  input logic err_clr,
  input logic sample_stb,
  input logic trig_err,
  input logic rise_evt,
  input logic fall_evt,
  input logic viol_evt
);
  p_pad_a_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_in_mode |-> (!pin_a_oe && !pin_a_out));

  p_pad_b_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_in_mode |-> (!pin_b_oe && !pin_b_out));

  p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_stb_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(fall_evt));

  p_viol_no_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> !sample_stb);

  p_viol_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> trig_err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_err && !err_clr) |=> trig_err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_err) |-> $past(viol_evt));

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_in_mode && !$past(trig_in_mode)) |-> (!sample_stb && !rise_evt && !viol_evt));
endmodule

bind irq_pin_trigger irq_pin_trigger_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_in_mode  (clk_in_mode),
  .trig_in_mode (trig_in_mode),
  .pin_a_out    (pin_a_out),
  .pin_a_oe     (pin_a_oe),
  .pin_b_out    (pin_b_out),
  .pin_b_oe     (pin_b_oe),
  .err_clr      (err_clr),
  .sample_stb   (sample_stb),
  .trig_err     (trig_err),
  .rise_evt     (rise_evt),
  .fall_evt     (fall_evt),
  .viol_evt     (viol_evt)
);

// File: tb/tb_irq_pin_trigger.sv
`timescale 1ns/1ps
module tb_irq_pin_trigger;
  localparam int HI  = 20;
  localparam int LO  = 20;
  localparam int PER = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_in_mode = 1'b0, trig_in_mode = 1'b0;
  logic irq_a = 1'b0, irq_b = 1'b0;
  logic pin_a_in = 1'b0, pin_b_in = 1'b0;
  logic err_clr = 1'b0;
  logic pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, ext_clk, sample_stb, trig_err;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;

  always #10 clk = ~clk;

  irq_pin_trigger #(.MIN_HIGH_CYC(HI), .MIN_LOW_CYC(LO), .MIN_PERIOD_CYC(PER)) dut (
    .clk(clk), .rst_n(rst_n), .clk_in_mode(clk_in_mode), .trig_in_mode(trig_in_mode),
    .irq_a(irq_a), .irq_b(irq_b), .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
    .err_clr(err_clr), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe), .ext_clk(ext_clk),
    .sample_stb(sample_stb), .trig_err(trig_err)
  );

  always @(negedge clk) if (sample_stb === 1'b1) stb_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called right after a falling clock edge; returns right after one.
  task automatic pulse(input int h, input int l);
    pin_b_in = 1'b1;
    repeat (h) @(negedge clk);
    pin_b_in = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 stb after reset", sample_stb, 0);
    check("R10 err after reset", trig_err, 0);
    check("R10 pad A oe", pin_a_oe, 1);
    check("R10 pad B oe", pin_b_oe, 1);
  endtask

  task automatic t_pads();
    irq_a = 1'b1; irq_b = 1'b1; #1;
    check("R1 pad A drives irq", pin_a_out, 1);
    check("R2 pad B drives irq", pin_b_out, 1);
    clk_in_mode = 1'b1; pin_a_in = 1'b1; #1;
    check("R1 pad A oe off", pin_a_oe, 0);
    check("R1 pad A out low", pin_a_out, 0);
    check("R2 pad B unaffected by A", pin_b_oe, 1);
    check("R3 ext clk high", ext_clk, 1);
    pin_a_in = 1'b0; #1;
    check("R3 ext clk low", ext_clk, 0);
    trig_in_mode = 1'b1; pin_a_in = 1'b1; #1;
    check("R2 pad B oe off", pin_b_oe, 0);
    check("R2 pad B out low", pin_b_out, 0);
    check("R3 ext clk with both modes", ext_clk, 1);
    clk_in_mode = 1'b0; #1;
    check("R3 ext clk gated", ext_clk, 0);
    check("R1 pad A drives again", pin_a_out, 1);
    @(negedge clk);
    repeat (2 * PER) @(negedge clk);
  endtask

  task automatic t_latency();
    int s[4];
    stb_cnt = 0;
    pin_b_in = 1'b1;
    repeat (25) @(negedge clk);
    pin_b_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      s[i] = int'(sample_stb);
    end
    check("R4 stb edge 1", s[0], 0);
    check("R4 stb edge 2", s[1], 0);
    check("R4 stb edge 3", s[2], 1);
    check("R4 stb edge 4", s[3], 0);
    repeat (2 * PER) @(negedge clk);
    check("R4 single strobe", stb_cnt, 1);
  endtask

  task automatic t_width();
    stb_cnt = 0;
    pulse(HI, 2 * PER);
    check("R5 exact width strobes", stb_cnt, 1);
    check("R5 exact width no err", trig_err, 0);
    stb_cnt = 0;
    pulse(HI - 1, 2 * PER);
    check("R5 short width no strobe", stb_cnt, 0);
    check("R5 short width err", trig_err, 1);
    repeat (10) @(negedge clk);
    check("R8 err sticky", trig_err, 1);
    clear_err();
    check("R8 err cleared", trig_err, 0);
  endtask

  task automatic t_gap();
    stb_cnt = 0;
    pulse(90, LO - 1);
    pulse(90, 2 * PER);
    check("R6 short gap drops second", stb_cnt, 1);
    check("R6 short gap err", trig_err, 1);
    clear_err();
    stb_cnt = 0;
    pulse(90, LO);
    pulse(90, 2 * PER);
    check("R6 exact gap both strobe", stb_cnt, 2);
    check("R6 exact gap no err", trig_err, 0);
  endtask

  task automatic t_period();
    stb_cnt = 0;
    pulse(40, 40);
    pulse(40, 2 * PER);
    check("R7 short period drops second", stb_cnt, 1);
    check("R7 short period err", trig_err, 1);
    clear_err();
    stb_cnt = 0;
    pulse(PER / 2, PER / 2);
    pulse(PER / 2, 2 * PER);
    check("R7 exact period both strobe", stb_cnt, 2);
    check("R7 exact period no err", trig_err, 0);
  endtask

  task automatic t_disabled();
    trig_in_mode = 1'b0;
    @(negedge clk);
    stb_cnt = 0;
    pulse(30, 5);
    pulse(3, 3);
    pulse(30, 2 * PER);
    check("R9 no strobe when off", stb_cnt, 0);
    check("R9 no err when off", trig_err, 0);
    check("R9 pad B drives irq", pin_b_out, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pads();
    t_latency();
    t_width();
    t_gap();
    t_period();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule